// File: doc/BRIEF.md
# Strap-Pin Slave Address Decoder

This block turns two address-strap pins into the variable part of a 7-bit I2C slave address, plus the power-up pullup-enable mask and default output level of an 8-bit port. Each strap can be wired to ground, to the supply, to the SDA line or to the SCL line. A strap wired to a static level cannot be told apart from one wired to a bus line that happens to sit at the same level. The block separates these cases by comparing each strap with SDA and SCL across a whole bus transmission.

All inputs arrive already synchronized to `clk`. A transmission opens at a START and closes at a STOP. The block watches every transmission on the bus, whether or not it is addressed. It reclassifies both straps when each one closes, and holds the result until the next STOP. Before the first complete transmission the bus is assumed idle-high, so a strap simply reports its static level and a strap wired to a bus line reads as high.

The strap `strap[1]` sets address bits 3:2 and governs port bits 7:4. The strap `strap[0]` sets address bits 1:0 and governs port bits 3:0.

Top module: `strap_addr_decoder`

## Requirements
- R1: Address bits 6:4 of `dev_addr` are always 1, 1, 0.
- R2: `dev_addr[3:2]` encodes the class of `strap[1]` as follows: SCL-tied = 00, SDA-tied = 01, low = 10, high = 11.
- R3: `dev_addr[1:0]` encodes the class of `strap[0]` as follows: low = 00, high = 01, SCL-tied = 10, SDA-tied = 11.
- R4: Until the first START-to-STOP transmission completes, each strap is classified as high or low from its sampled level. Outputs follow one clock after the sample. From the START onward this tracking freezes, so an SDA- or SCL-tied strap keeps reading high.
- R5: A strap equal to SDA in every sample from START through STOP, with at least one SDA change after START, is classified SDA-tied.
- R6: A strap equal to SCL in every sample from START through STOP, with at least one SCL change after START, is classified SCL-tied. If SCL never changed in the window, the strap is classified by level.
- R7: A strap that differs from a line in any sample of the window is not classified as tied to that line. It takes its static class, which is its level in the STOP sample.
- R8: Classification is redone at the STOP of every transmission, whatever address is sent. The new result appears one clock after the STOP sample. After the first STOP, outputs do not change at any other time, even if strap levels change.
- R9: `pull_en[3:0]` and `dflt_lvl[3:0]` are all ones unless `strap[0]` is classed low, in which case they are all zeros. Bits 7:4 behave the same way for `strap[1]`.
- R10: A repeated START restarts the observation window, so mismatches seen before it are discarded.
- R11: While reset is asserted, both straps are classed high: `dev_addr` = 7'b1101101, `pull_en` = `dflt_lvl` = 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap | input | 2 | Synchronized strap levels; bit 1 sets address bits 3:2, bit 0 sets bits 1:0 |
| sda | input | 1 | Synchronized SDA level |
| scl | input | 1 | Synchronized SCL level |
| dev_addr | output | 7 | Decoded 7-bit slave address |
| pull_en | output | 8 | Pullup enable per port bit |
| dflt_lvl | output | 8 | Power-up default level per port bit |

## Verification
Every result is due exactly one clock after the sample that causes it. Before the first STOP, a strap level sampled at one rising edge shows on the outputs after that edge. The reclassification occurs at the rising edge that samples the STOP condition. The bench changes bus and strap levels only on falling edges and compares all three outputs at the following falling edge. Each check therefore lands after the single register stage and before any new stimulus is applied.

// File: rtl/strap_addr_decoder.sv
module strap_addr_decoder #(
  parameter logic [2:0] ADDR_PREFIX = 3'b110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] strap,
  input  logic       sda,
  input  logic       scl,
  output logic [6:0] dev_addr,
  output logic [7:0] pull_en,
  output logic [7:0] dflt_lvl
);

  localparam logic [1:0] C_LOW  = 2'd0;
  localparam logic [1:0] C_HIGH = 2'd1;
  localparam logic [1:0] C_SCL  = 2'd2;
  localparam logic [1:0] C_SDA  = 2'd3;

  logic       sda_q, scl_q, busy, resolved;
  logic       esda, escl, n_esda, n_escl;
  logic [1:0] msda, mscl, n_msda, n_mscl;
  logic [1:0] cls [2];
  logic [1:0] judged [2];

  wire start = scl & scl_q & sda_q & ~sda;
  wire stop  = scl & scl_q & ~sda_q & sda;

  always_comb begin
    n_esda = start ? 1'b0 : (esda | (sda ^ sda_q));
    n_escl = start ? 1'b0 : (escl | (scl ^ scl_q));
    for (int i = 0; i < 2; i++) begin
      n_msda[i] = (strap[i] == sda) & (start | msda[i]);
      n_mscl[i] = (strap[i] == scl) & (start | mscl[i]);
      if (n_msda[i] && n_esda)      judged[i] = C_SDA;
      else if (n_mscl[i] && n_escl) judged[i] = C_SCL;
      else                          judged[i] = strap[i] ? C_HIGH : C_LOW;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q    <= 1'b1;
      scl_q    <= 1'b1;
      busy     <= 1'b0;
      resolved <= 1'b0;
      esda     <= 1'b0;
      escl     <= 1'b0;
      msda     <= '0;
      mscl     <= '0;
      cls[0]   <= C_HIGH;
      cls[1]   <= C_HIGH;
    end else begin
      sda_q <= sda;
      scl_q <= scl;
      esda  <= n_esda;
      escl  <= n_escl;
      msda  <= n_msda;
      mscl  <= n_mscl;
      if (start)     busy <= 1'b1;
      else if (stop) busy <= 1'b0;
      if (busy && stop) begin
        resolved <= 1'b1;
        cls[0]   <= judged[0];
        cls[1]   <= judged[1];
      end else if (!resolved && !busy && !start) begin
        cls[0] <= strap[0] ? C_HIGH : C_LOW;
        cls[1] <= strap[1] ? C_HIGH : C_LOW;
      end
    end
  end

  assign dev_addr = {ADDR_PREFIX, cls[1] ^ 2'b10, cls[0]};
  assign pull_en  = {{4{cls[1] != C_LOW}}, {4{cls[0] != C_LOW}}};
  assign dflt_lvl = pull_en;

  AST_HOLD_AFTER_RESOLVE: assert property (@(posedge clk) disable iff (!rst_n)
    (resolved && !(busy && stop)) |=> $stable(dev_addr)); // R8
  AST_RESOLVED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    resolved |=> resolved); // R8
  AST_PRE_RESOLVE_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (!resolved && !busy && !start) |=> (dev_addr[1:0] == {1'b0, $past(strap[0])})); // R4
  AST_LO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    pull_en[3:0] == {4{dev_addr[1:0] != 2'b00}}); // R9
  AST_HI_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    pull_en[7:4] == {4{dev_addr[3:2] != 2'b10}}); // R9

endmodule

// File: tb/strap_addr_decoder_test.sv
module strap_addr_decoder_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] strap = 2'b11;
  logic       sda = 1'b1, scl = 1'b1;
  logic [6:0] dev_addr;
  logic [7:0] pull_en, dflt_lvl;

  int checks = 0, fails = 0;
  int mh = 1, ml = 1;
  bit done = 0;

  always #4 clk = ~clk;

  strap_addr_decoder uut (.clk(clk), .rst_n(rst_n), .strap(strap), .sda(sda), .scl(scl),
                          .dev_addr(dev_addr), .pull_en(pull_en), .dflt_lvl(dflt_lvl));

  // {hi mode, lo mode, expected address}; modes 0 low, 1 high, 2 SCL, 3 SDA
  localparam logic [10:0] VEC [16] = '{
    {2'd0, 2'd0, 7'b1101000}, {2'd0, 2'd1, 7'b1101001}, {2'd0, 2'd2, 7'b1101010}, {2'd0, 2'd3, 7'b1101011},
    {2'd1, 2'd0, 7'b1101100}, {2'd1, 2'd1, 7'b1101101}, {2'd1, 2'd2, 7'b1101110}, {2'd1, 2'd3, 7'b1101111},
    {2'd2, 2'd0, 7'b1100000}, {2'd2, 2'd1, 7'b1100001}, {2'd2, 2'd2, 7'b1100010}, {2'd2, 2'd3, 7'b1100011},
    {2'd3, 2'd0, 7'b1100100}, {2'd3, 2'd1, 7'b1100101}, {2'd3, 2'd2, 7'b1100110}, {2'd3, 2'd3, 7'b1100111}
  };

  function automatic logic pv(int m, logic d, logic c);
    case (m)
      0: return 1'b0;
      1: return 1'b1;
      2: return c;
      3: return d;
      default: return d & c;
    endcase
  endfunction

  task automatic drive(logic d, logic c);
    sda = d; scl = c;
    strap = {pv(mh, d, c), pv(ml, d, c)};
    @(negedge clk);
  endtask

  task automatic send_start(); drive(1, 1); drive(0, 1); endtask
  task automatic send_rstart(); drive(1, 0); drive(1, 1); drive(0, 1); endtask
  task automatic send_stop(); drive(0, 0); drive(0, 1); drive(1, 1); endtask
  task automatic send_byte(logic [7:0] b);
    drive(0, 0);
    for (int i = 7; i >= 0; i--) begin
      drive(b[i], 0); drive(b[i], 1); drive(b[i], 0);
    end
  endtask

  function automatic logic [7:0] mask_of(logic [6:0] a);
    return {{4{a[3:2] != 2'b10}}, {4{a[1:0] != 2'b00}}};
  endfunction

  task automatic chk(string req, logic [6:0] ea);
    logic [7:0] em;
    em = mask_of(ea);
    checks++;
    if (dev_addr !== ea || pull_en !== em || dflt_lvl !== em) begin
      fails++;
      $display("FAIL %s: addr=%b pull=%h lvl=%h expected addr=%b pull=%h lvl=%h",
               req, dev_addr, pull_en, dflt_lvl, ea, em, em);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R11 R1 reset state", 7'b1101101);
    mh = 1; ml = 0;
    drive(1, 1);
    rst_n = 1'b1;
    drive(1, 1);
    chk("R4 R2 R3 static levels before first transmission", 7'b1101100);
    mh = 3; ml = 2;
    drive(1, 1);
    chk("R4 bus-tied straps read high while idle", 7'b1101101);
    send_start();
    drive(0, 0);
    chk("R4 frozen during first transmission", 7'b1101101);
    send_byte(8'h42);
    send_stop();
    chk("R5 R6 first classification at STOP", 7'b1100110);

    for (int v = 0; v < 16; v++) begin
      mh = int'(VEC[v][10:9]); ml = int'(VEC[v][8:7]);
      drive(1, 1); drive(1, 1);
      send_start();
      send_byte(8'h42);
      send_stop();
      chk("R2 R3 R5 R6 R8 R9 vector table", VEC[v][6:0]);
    end

    mh = 0; ml = 0;
    repeat (4) drive(1, 1);
    chk("R8 strap change outside transmission ignored", 7'b1100111);

    mh = 3; ml = 2;
    send_start();
    drive(1, 1);
    chk("R6 no SCL transition gives level class", 7'b1100101);

    mh = 4; ml = 0;
    send_start();
    send_byte(8'h42);
    send_stop();
    chk("R7 mismatched strap takes STOP level", 7'b1101100);

    mh = 4; ml = 1;
    send_start();
    send_byte(8'h42);
    mh = 3;
    send_rstart();
    send_byte(8'h42);
    send_stop();
    chk("R10 repeated START restarts window", 7'b1100101);

    finish_up();
  end
endmodule